// File: doc/BRIEF.md
# Eight-Channel DMA Priority Arbiter

This block chooses which of eight DMA channels may use the transfer engine next. Each bit of the request vector is one channel. The bit is already qualified by that channel's own enable, the global enable and the error state, so the arbiter only has to rank the requests. A two-bit mode input selects the ranking. Three modes are fixed orderings: plain ascending order, ascending order with channel 1 moved to the bottom, and ascending order with channel 2 moved to the top. The fourth mode is a rotating round-robin ranking.

The grant is combinational from the request vector, the mode and a registered round-robin pointer. A caller can therefore change the mode at any time, and the new ranking applies to the very next arbitration. The pointer names the highest-ranked channel in round-robin mode. A transfer-done strobe moves it only in round-robin mode, and only while a grant is present. The channel that just finished then drops to the lowest rank. The mode value itself comes from register logic outside this block; that logic is expected to reset it to 00.

Top module: `dma_arb_top`

## Requirements
- R1: After a synchronous active-low reset, the round-robin pointer makes channel 0 the highest-ranked channel; with mode 11 and all requests set, the grant is 8'h01.
- R2: valid_o is 1 exactly when at least one request bit is set; with no request, grant_o is all zero.
- R3: grant_o has at most one bit set, and that bit is always set in req_i.
- R4: With mode 00, the ranking from highest to lowest is channels 0,1,2,3,4,5,6,7.
- R5: With mode 01, the ranking is 0,2,3,4,5,6,7,1, so channel 1 wins only when no other channel requests.
- R6: With mode 10, the ranking is 2,0,1,3,4,5,6,7, so channel 2 beats every other channel.
- R7: With mode 11, the pointer channel ranks highest, and the ranking then rises through the channel numbers, wrapping from 7 to 0.
- R8: A done_i high at a clock edge with mode 11 and valid_o high moves the pointer to the granted channel plus one, modulo 8. The finished channel then ranks lowest; a grant of channel 7 wraps the pointer to 0.
- R9: The pointer does not move on done_i in modes 00, 01 or 10, nor when done_i arrives with no request present.
- R10: The grant follows the mode and the requests without a clock edge, so a mode change applies to the next arbitration with no stale grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | 8 | Qualified request, one bit per channel |
| mode_i | input | 2 | Ranking mode: 00, 01, 10 fixed; 11 round robin |
| done_i | input | 1 | One-cycle strobe marking the end of the granted transfer |
| grant_o | output | 8 | One-hot grant, zero when idle |
| valid_o | output | 1 | A grant is present |

## Verification
The bench builds the block with its default of eight channels and a three-bit pointer. This is the only size the fixed orderings are defined for. With these values the pointer can be driven through all eight positions, including the wrap from channel 7 back to channel 0 that R7 and R8 single out. The vector table covers each fixed mode with requests that either include or omit the promoted or demoted channel. The directed tests cover rotation, done strobes that must be ignored, a same-cycle mode switch, and a reset that restores the pointer.

// File: rtl/dma_arb_pkg.sv
// Shared constants and types for the DMA priority arbiter.
// Assumes a channel count that is a power of two, so the round-robin
// pointer wraps naturally in its own width.
package dma_arb_pkg;
    localparam int CH_NUM = 8;
    localparam int CH_IDX_W = $clog2(CH_NUM);

    typedef enum logic [1:0] {
        MODE_ASCEND = 2'b00,
        MODE_ONE_LAST = 2'b01,
        MODE_TWO_FIRST = 2'b10,
        MODE_ROTATE = 2'b11
    } arb_mode_e;
endpackage

// File: rtl/dma_arb_order.sv
// Builds the ranked list of channel numbers for the selected mode.
// Slot 0 holds the highest-ranked channel. It assumes at least three
// channels, because two of the fixed modes move channel 1 and channel 2.
module dma_arb_order
    import dma_arb_pkg::*;
#(
    parameter int N = CH_NUM,
    localparam int W = $clog2(N)
) (
    input  logic [1:0]        mode,
    input  logic [W-1:0]      top_ch,
    output logic [N-1:0][W-1:0] order
);
    for (genvar p = 0; p < N; p++) begin : g_slot
        // Choose the channel held in slot p for the current mode.
        always_comb begin
            unique case (arb_mode_e'(mode))
                MODE_ASCEND:    order[p] = W'(p);
                MODE_ONE_LAST:  order[p] = (p == 0) ? W'(0) :
                                           (p == N - 1) ? W'(1) : W'(p + 1);
                MODE_TWO_FIRST: order[p] = (p == 0) ? W'(2) :
                                           (p == 1) ? W'(0) :
                                           (p == 2) ? W'(1) : W'(p);
                default:        order[p] = top_ch + W'(p);
            endcase
        end
    end
endmodule

// File: rtl/dma_arb_pick.sv
// Walks a ranked channel list and grants the first channel that requests.
// Assumes the list is a permutation of all channel numbers.
module dma_arb_pick #(
    parameter int N = 8,
    localparam int W = $clog2(N)
) (
    input  logic [N-1:0]        req,
    input  logic [N-1:0][W-1:0] order,
    output logic [N-1:0]        grant,
    output logic [W-1:0]        grant_idx,
    output logic                valid
);
    // Scan the slots from highest to lowest rank and stop at the first hit.
    always_comb begin
        grant = '0;
        grant_idx = '0;
        valid = 1'b0;
        for (int p = 0; p < N; p++) begin
            if (!valid && req[order[p]]) begin
                valid = 1'b1;
                grant_idx = order[p];
                grant[order[p]] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dma_arb_rr_ptr.sv
// Holds the round-robin pointer, i.e. the highest-ranked channel in rotate mode.
// The pointer moves past the granted channel when a transfer completes.
// Assumes done arrives while the grant of the finishing channel is still shown.
module dma_arb_rr_ptr #(
    parameter int N = 8,
    localparam int W = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rotate,
    input  logic         done,
    input  logic         valid,
    input  logic [W-1:0] grant_idx,
    output logic [W-1:0] top_ch
);
    // Reset to channel 0, then step past the finished channel on done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_ch <= '0;
        end else if (rotate && done && valid) begin
            top_ch <= grant_idx + W'(1);
        end
    end

    p_ptr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rotate && done && valid) |=> $stable(top_ch));

    p_ptr_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (top_ch == '0));
endmodule

// File: rtl/dma_arb_top.sv
// Eight-channel DMA priority arbiter: picks one qualified request per
// arbitration cycle, using one of three fixed rankings or round robin.
// Assumes the requests already include the enable and error qualification,
// and that the mode register outside this block resets to 00.
module dma_arb_top
    import dma_arb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CH_NUM-1:0] req_i,
    input  logic [1:0]        mode_i,
    input  logic              done_i,
    output logic [CH_NUM-1:0] grant_o,
    output logic              valid_o
);
    logic [CH_NUM-1:0][CH_IDX_W-1:0] order;
    logic [CH_IDX_W-1:0]             top_ch;
    logic [CH_IDX_W-1:0]             grant_idx;
    logic                            rotate;

    // Round-robin mode decode for the pointer register.
    always_comb rotate = (arb_mode_e'(mode_i) == MODE_ROTATE);

    dma_arb_order #(.N(CH_NUM)) u_order (
        .mode   (mode_i),
        .top_ch (top_ch),
        .order  (order)
    );

    dma_arb_pick #(.N(CH_NUM)) u_pick (
        .req       (req_i),
        .order     (order),
        .grant     (grant_o),
        .grant_idx (grant_idx),
        .valid     (valid_o)
    );

    dma_arb_rr_ptr #(.N(CH_NUM)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .rotate    (rotate),
        .done      (done_i),
        .valid     (valid_o),
        .grant_idx (grant_idx),
        .top_ch    (top_ch)
    );

    p_valid_any_r2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o == (req_i != '0));

    p_grant_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o) && ((grant_o & ~req_i) == '0));

    p_ascend_ch0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b00 && req_i[0]) |-> grant_o[0]);

    p_one_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b01 && (req_i & ~CH_NUM'(2)) != '0) |-> !grant_o[1]);

    p_two_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b10 && req_i[2]) |-> grant_o[2]);

    p_rotate_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rotate && req_i[top_ch]) |-> grant_o[top_ch]);

    p_ptr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rotate && done_i && valid_o) |=> (top_ch == $past(grant_idx) + CH_IDX_W'(1)));
endmodule

// File: tb/tb_dma_arb_top.sv
module tb_dma_arb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 13;
    // Each entry: {mode[17:16], req[15:8], expected grant[7:0]}; pointer at channel 0.
    localparam logic [17:0] VEC [NVEC] = '{
        {2'b00, 8'hFF, 8'h01}, {2'b00, 8'h80, 8'h80}, {2'b00, 8'h0C, 8'h04},
        {2'b01, 8'h03, 8'h01}, {2'b01, 8'h82, 8'h80}, {2'b01, 8'h02, 8'h02},
        {2'b01, 8'h06, 8'h04}, {2'b10, 8'h07, 8'h04}, {2'b10, 8'h03, 8'h01},
        {2'b10, 8'h0A, 8'h02}, {2'b11, 8'hFF, 8'h01}, {2'b11, 8'h80, 8'h80},
        {2'b00, 8'h00, 8'h00}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] req = '0;
    logic [1:0] mode = '0;
    logic done = 1'b0;
    logic [7:0] grant;
    logic valid;
    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dma_arb_top dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .mode_i(mode),
        .done_i(done), .grant_o(grant), .valid_o(valid)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic drive(input logic [1:0] m, input logic [7:0] r);
        @(negedge clk);
        mode = m;
        req = r;
        #1;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: pointer at channel 0 after reset
        drive(2'b11, 8'hFF);
        check("R1 reset rotate grant", grant, 8'h01);

        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i][17:16], VEC[i][15:8]);
            check($sformatf("R4/R5/R6/R7 vector %0d", i), grant, VEC[i][7:0]);
            check("R2 valid", {7'b0, valid}, {7'b0, VEC[i][15:8] != 8'h00});
        end

        // R10: same requests, mode switch shows new ranking without a clock
        drive(2'b00, 8'h06);
        check("R10 mode 00", grant, 8'h02);
        mode = 2'b01;
        #1;
        check("R10 mode 01 same cycle", grant, 8'h04);

        // R8: rotation steps past the finished channel
        drive(2'b11, 8'hFF);
        pulse_done();
        check("R8 after ch0 done", grant, 8'h02);
        pulse_done();
        check("R8 after ch1 done", grant, 8'h04);
        drive(2'b11, 8'h01);
        check("R7 wrap ranking", grant, 8'h01);
        drive(2'b11, 8'h80);
        pulse_done();
        drive(2'b11, 8'hFF);
        check("R8 wrap 7 to 0", grant, 8'h01);

        // R9: done ignored in fixed modes and with no request
        drive(2'b00, 8'hFF);
        pulse_done();
        drive(2'b10, 8'hFF);
        pulse_done();
        drive(2'b11, 8'h00);
        check("R2 idle grant", grant, 8'h00);
        pulse_done();
        drive(2'b11, 8'hFF);
        check("R9 pointer held", grant, 8'h01);

        // R1: reset mid-run restores the pointer
        pulse_done();
        pulse_done();
        check("R8 pointer at 2", grant, 8'h04);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 pointer restored", grant, 8'h01);

        // R3: grant never outside requests in rotate mode
        drive(2'b11, 8'h50);
        check("R3 subset", grant, 8'h10);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule